// File: doc/BRIEF.md
# Display Attach Detector with Change Interrupt

This block decides whether a display is attached to the transmitter and tells the host when that answer changes. It can watch one of two sources: a level that reports a powered receiver on the link, or the asynchronous hot-plug pin from the connector. A control input chooses the source, and its low value, which is the reset value of the bit that drives it, picks the receiver-sense level. The host can read the filtered result on `attached` at any time. A receiver only reports itself once the monitor is powered, so every change of the attach state has to be visible to the host, which can then fetch the display's identification data again.

Both raw inputs pass through a two-stage synchroniser. A debounce filter then accepts a new level only after it has held for a programmable number of clock cycles. Each accepted change, rising or falling, sets a sticky pending flag. The host clears this flag by writing a one to an acknowledge strobe. The interrupt request is the pending flag gated by an enable. Switching the source loads the filter straight from the newly chosen input and does not raise the pending flag. The hot-plug pin is pulled down on the board, so a floating pin reads as not attached.

Top module: `attach_detect`

## Requirements
- R1: While `rst_n` is low, `attached`, `pending` and `irq` are low, without waiting for a clock edge. They stay low after reset until a filtered input change is accepted.
- R2: With `src_sel` = 0, `attached` follows `rsense_in` only, and changes on `hpd_pin` have no effect on any output.
- R3: With `src_sel` = 1, `attached` follows `hpd_pin` only, and changes on `rsense_in` have no effect on any output.
- R4: A level change on the selected input that holds for at least `DEB_CYCLES` filter cycles shows on `attached` at exactly the (`DEB_CYCLES`+2)-th rising clock edge after the change. A change lasting fewer than `DEB_CYCLES` cycles is ignored.
- R5: An accepted change of `attached` in either direction sets `pending` at the same clock edge.
- R6: `pending` stays high until `ack_clr` is high at a rising edge. If an accepted change and `ack_clr` fall on the same edge, `pending` stays high.
- R7: `irq` is high exactly when `pending` is high and `irq_en` is high. Raising `irq_en` while an event is pending raises `irq`.
- R8: A change of `src_sel` loads `attached` from the newly selected synchronised input without a debounce delay and without setting `pending`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hpd_pin | input | 1 | Asynchronous hot-plug level from the connector |
| rsense_in | input | 1 | Receiver-sense level, 1 = powered receiver present |
| src_sel | input | 1 | Attach source: 0 = receiver sense, 1 = hot-plug |
| irq_en | input | 1 | Interrupt enable |
| ack_clr | input | 1 | Write-one-to-clear strobe for the pending flag |
| attached | output | 1 | Filtered attach status |
| pending | output | 1 | Sticky attach-change flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `DEB_CYCLES` = 4 instead of the default 16. With this value the exact acceptance edge and the rejection of a pulse one cycle too short can be checked in a few cycles each. It also lets the bench place an acknowledge on the very edge where a change is accepted. With the short window, every source switch, masking case and acknowledge order can be walked in a short table.

// File: rtl/attach_pkg.sv
package attach_pkg;
  typedef enum logic {
    SRC_RSENSE  = 1'b0,
    SRC_HOTPLUG = 1'b1
  } src_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/attach_sync.sv
module attach_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_in;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/attach_filter.sv
module attach_filter
  import attach_pkg::*;
#(
  parameter int unsigned DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  src_e src_sel,
  input  logic hp_s,
  input  logic rs_s,
  output logic state,
  output logic flip
);
  localparam int unsigned CW = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  src_e          sel_q;
  logic          state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cand, swap, differ, upd_en;

  assign cand   = (src_sel == SRC_HOTPLUG) ? hp_s : rs_s;
  assign swap   = (sel_q != src_sel);
  assign differ = (cand != state_q);
  assign upd_en = swap || differ || (cnt_q != '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    flip    = 1'b0;
    if (swap) begin
      state_d = cand;
      cnt_d   = '0;
    end else if (!differ) begin
      cnt_d   = '0;
    end else if (cnt_q == LAST) begin
      state_d = cand;
      cnt_d   = '0;
      flip    = 1'b1;
    end else begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SRC_RSENSE;
    end else begin
      sel_q <= src_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/attach_flag.sv
module attach_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  input  logic irq_en,
  output logic pend,
  output logic irq
);
  logic pend_q, pend_d, pend_en;

  assign pend_en = set_ev || clr_ev;

  always_comb begin
    pend_d = pend_q;
    if (set_ev) begin
      pend_d = 1'b1;
    end else if (clr_ev) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
  assign irq  = pend_q & irq_en;
endmodule

// File: rtl/attach_detect.sv
module attach_detect
  import attach_pkg::*;
#(
  parameter int unsigned DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hpd_pin,
  input  logic rsense_in,
  input  logic src_sel,
  input  logic irq_en,
  input  logic ack_clr,
  output logic attached,
  output logic pending,
  output logic irq
);
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_int_n;
  logic [1:0]             raw_s;
  logic                   flip;
  src_e                   sel_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[SYNC_STAGES-1];

  assign sel_e = src_e'(src_sel);

  attach_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in ({hpd_pin, rsense_in}),
    .sync_out (raw_s)
  );

  attach_filter #(
    .DEB_CYCLES (DEB_CYCLES)
  ) u_filter (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .src_sel (sel_e),
    .hp_s    (raw_s[1]),
    .rs_s    (raw_s[0]),
    .state   (attached),
    .flip    (flip)
  );

  attach_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_ev (flip),
    .clr_ev (ack_clr),
    .irq_en (irq_en),
    .pend   (pending),
    .irq    (irq)
  );
endmodule

// File: rtl/attach_detect_chk.sv
module attach_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic src_sel,
  input logic irq_en,
  input logic ack_clr,
  input logic attached,
  input logic pending,
  input logic irq
);
  // R6: pending drops only after an acknowledge
  a_r6_clear_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(ack_clr));

  // R6: pending holds while no acknowledge arrives
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pending) && !$past(ack_clr)) |-> pending);

  // R5: pending rises only together with a change of the attach state
  a_r5_rise_with_change: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> !$stable(attached));

  // R5: a change under an unchanged source always leaves an event pending
  a_r5_change_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(attached) && ($past(src_sel) == $past(src_sel, 2))) |-> pending);

  // R7: a masked event never requests an interrupt
  a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind attach_detect attach_detect_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_sel  (src_sel),
  .irq_en   (irq_en),
  .ack_clr  (ack_clr),
  .attached (attached),
  .pending  (pending),
  .irq      (irq)
);

// File: tb/tb_attach_detect.sv
module tb_attach_detect;
  localparam int unsigned DEB    = 4;
  localparam int unsigned SETTLE = DEB + 4;
  localparam int unsigned NVEC   = 13;

  // {src_sel, rsense, hpd, irq_en, ack, exp_attached, exp_pending, exp_irq}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b0_0_0_0_0_000,
    8'b0_1_0_0_0_110,
    8'b0_1_0_1_0_111,
    8'b0_1_0_1_1_100,
    8'b0_1_1_1_0_100,
    8'b0_0_1_1_0_011,
    8'b0_0_1_1_1_000,
    8'b1_0_1_1_0_100,
    8'b1_1_1_1_0_100,
    8'b1_1_0_1_0_011,
    8'b1_1_0_0_0_010,
    8'b1_1_0_0_1_000,
    8'b0_1_0_0_0_100
  };

  logic clk = 1'b0;
  logic rst_n, hpd_pin, rsense_in, src_sel, irq_en, ack_clr;
  logic attached, pending, irq;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  attach_detect #(.DEB_CYCLES(DEB)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .hpd_pin   (hpd_pin),
    .rsense_in (rsense_in),
    .src_sel   (src_sel),
    .irq_en    (irq_en),
    .ack_clr   (ack_clr),
    .attached  (attached),
    .pending   (pending),
    .irq       (irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic string row_tag(input int i);
    case (i)
      0:        return "R1 row0 idle";
      1, 2:     return "R7 row mask/enable";
      3, 6, 11: return "R6 row acknowledge";
      4:        return "R2 row hpd ignored";
      5:        return "R5 row falling change";
      7, 12:    return "R8 row source switch";
      8:        return "R3 row rsense ignored";
      9:        return "R3 row hpd change";
      default:  return "R7 row masked";
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hpd_pin = 1'b0; rsense_in = 1'b0;
    src_sel = 1'b0; irq_en = 1'b0; ack_clr = 1'b0;
    tick(3);
    chk("R1 reset attached", attached, 1'b0);
    chk("R1 reset pending", pending, 1'b0);
    chk("R1 reset irq", irq, 1'b0);
    rst_n = 1'b1;
    tick(6);

    for (int i = 0; i < NVEC; i++) begin
      src_sel   = VEC[i][7];
      rsense_in = VEC[i][6];
      hpd_pin   = VEC[i][5];
      irq_en    = VEC[i][4];
      tick(SETTLE);
      if (VEC[i][3]) begin
        ack_clr = 1'b1;
        tick(1);
        ack_clr = 1'b0;
        tick(1);
      end
      chk({row_tag(i), " attached"}, attached, VEC[i][2]);
      chk({row_tag(i), " pending"},  pending,  VEC[i][1]);
      chk({row_tag(i), " irq"},      irq,      VEC[i][0]);
    end

    // R4: a pulse one cycle shorter than the window is rejected
    rsense_in = 1'b0;
    tick(DEB - 1);
    rsense_in = 1'b1;
    tick(SETTLE);
    chk("R4 short pulse attached", attached, 1'b1);
    chk("R4 short pulse pending", pending, 1'b0);

    // R4: exact acceptance edge, R5 falling change sets pending
    rsense_in = 1'b0;
    tick(DEB + 1);
    chk("R4 before acceptance edge", attached, 1'b1);
    tick(1);
    chk("R4 at acceptance edge", attached, 1'b0);
    chk("R5 falling sets pending", pending, 1'b1);

    // R6: acknowledge on the acceptance edge loses to the new event
    rsense_in = 1'b1;
    tick(DEB + 1);
    ack_clr = 1'b1;
    tick(1);
    ack_clr = 1'b0;
    chk("R5 rising accepted", attached, 1'b1);
    chk("R6 set wins over ack", pending, 1'b1);
    ack_clr = 1'b1;
    tick(1);
    ack_clr = 1'b0;
    tick(1);
    chk("R6 ack clears", pending, 1'b0);

    // R7: enable with nothing pending, then an event arrives
    irq_en = 1'b1;
    tick(1);
    chk("R7 enabled idle irq", irq, 1'b0);
    rsense_in = 1'b0;
    tick(SETTLE);
    chk("R7 event raises irq", irq, 1'b1);

    // R1: asynchronous reset mid-run, then receiver sense is the source
    hpd_pin = 1'b1;
    rsense_in = 1'b1;
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async reset attached", attached, 1'b0);
    chk("R1 async reset pending", pending, 1'b0);
    chk("R1 async reset irq", irq, 1'b0);
    tick(2);
    rsense_in = 1'b0;
    rst_n = 1'b1;
    tick(SETTLE + 2);
    chk("R2 after reset hpd ignored", attached, 1'b0);
    chk("R1 after reset no event", pending, 1'b0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule